// File: doc/BRIEF.md
# Mixed-width dual-port RAM

This block is a behavioural model of a true dual-port synchronous RAM with two identical read+write ports, A and B. Both ports sit on one rising clock edge and share one storage array. Each port picks its own data width from a fixed ladder of 1, 2, 4, 9 and 18 bits through a static select input. Each port also picks its own read-during-write behaviour: hold, old data or new data. An enabled port accepts one access in every cycle and never stalls. There is no valid/ready handshake because the port has no back-pressure: a clock enable marks the cycles that carry an access.

Addresses are always 13 bits at 1-bit granularity. A wider access ignores the low address bits that fall inside its word. Storage is organised as 9-bit words: eight data bits plus one extra bit. A 2-bit or 4-bit access selects a slice of the eight data bits. A 9-bit access covers one whole word. An 18-bit access covers an even/odd pair of words. Each word of 9 data bits has one write-enable bit. The array starts from a parameter-supplied vector. The read data register is cleared by reset.

Top module: `mwdp_ram`

## Requirements
- R1: While `rst_n` is low, `a_rdata` and `b_rdata` are zero.
- R2: Width codes are 0=1 bit, 1=2 bits, 2=4 bits, 3=9 bits and 4=18 bits; reserved codes 5 to 7 act as 1 bit. Bit i of a 1-bit address `a` is data bit a[2:0] of word a[12:3]. A 9-bit word holds the 4-bit words at the two lower addresses in bits [3:0] and [7:4], and its extra bit in bit 8. An 18-bit word holds word 2k in bits [8:0] and word 2k+1 in bits [17:9], where k is addr[12:4]. A narrower access can never reach bit 8.
- R3: For widths under 18, rdata bits at and above the port width read as zero.
- R4: Address bits below the selected width's granularity have no effect: bits [0], [1:0], [2:0] and [3:0] for widths 2, 4, 9 and 18.
- R5: Enable bit 0 covers data bits [8:0] and enable bit 1 covers bits [17:9] at width 18. At every narrower width, bit 0 covers the whole port and bit 1 is ignored. A port is writing when any enable bit that applies to its width is set.
- R6: With the clock enable low, the port neither writes nor reads, and its rdata holds its value.
- R7: Mode code 0 (hold): a writing port leaves its rdata unchanged. A non-writing port reads normally.
- R8: Mode code 1 (old) and reserved code 3: a writing port returns the contents as they were before the write.
- R9: Mode code 2 (new): a writing port returns its own write data on the enabled bits and the prior contents on all other bits.
- R10: If both ports write the same bit in the same cycle, port A's value is stored.
- R11: A port that reads bits the other port writes in the same cycle returns the old contents.
- R12: Read data appears on the edge that samples the access, a latency of one cycle. Unwritten storage reads as the `INIT_VEC` parameter (default all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Asynchronous active-low clear of both read registers |
| a_ce | input | 1 | Port A clock enable, gates read and write |
| a_wsel | input | 3 | Port A width code |
| a_rdw | input | 2 | Port A read-during-write mode code |
| a_addr | input | 13 | Port A address, 1-bit granularity |
| a_wdata | input | 18 | Port A write data, right-aligned |
| a_be | input | 2 | Port A per-9-bit write enables |
| a_rdata | output | 18 | Port A registered read data |
| b_ce | input | 1 | Port B clock enable |
| b_wsel | input | 3 | Port B width code |
| b_rdw | input | 2 | Port B read-during-write mode code |
| b_addr | input | 13 | Port B address, 1-bit granularity |
| b_wdata | input | 18 | Port B write data, right-aligned |
| b_be | input | 2 | Port B per-9-bit write enables |
| b_rdata | output | 18 | Port B registered read data |

## Verification
A wrong slice position, a lost merge between ports or a bad enable mask leaves hidden storage wrong. It stays invisible until some port reads the affected bits. The read may come at any width, and its result appears one cycle after that read. A fault in the mode logic instead shows at once, on the rdata of the very cycle that follows the write. The bench therefore keeps a flat bit-level image of the storage and compares both rdata buses after every edge. It runs every pairing of widths and modes over a small address window, so corrupted bits are read back within a few cycles.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;
  localparam int ADDR_W    = 13;
  localparam int DATA_W    = 18;
  localparam int WORD_W    = 9;
  localparam int BE_W      = DATA_W / WORD_W;
  localparam int PAIR_AW   = ADDR_W - 4;
  localparam int PAIRS     = 1 << PAIR_AW;
  localparam int POS_W     = $clog2(DATA_W);
  localparam int INIT_BITS = PAIRS * DATA_W;

  typedef enum logic [2:0] {
    WS_1 = 3'd0, WS_2 = 3'd1, WS_4 = 3'd2, WS_9 = 3'd3, WS_18 = 3'd4
  } wsel_e;

  typedef enum logic [1:0] {
    RDW_HOLD = 2'd0, RDW_OLD = 2'd1, RDW_NEW = 2'd2
  } rdw_e;

  // lane mask (right-aligned) for a width code
  function automatic logic [DATA_W-1:0] lane_of(input logic [2:0] ws);
    case (ws)
      WS_2:    return DATA_W'(2'h3);
      WS_4:    return DATA_W'(4'hf);
      WS_9:    return DATA_W'(9'h1ff);
      WS_18:   return '1;
      default: return DATA_W'(1'b1);
    endcase
  endfunction
endpackage

// File: rtl/mwdp_port_map.sv
module mwdp_port_map
  import mwdp_pkg::*;
(
  input  logic               ce,
  input  logic [2:0]         wsel,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BE_W-1:0]    be,
  output logic [PAIR_AW-1:0] pair,
  output logic [POS_W-1:0]   pos,
  output logic [DATA_W-1:0]  lane,
  output logic [DATA_W-1:0]  wr_lane,
  output logic               wr_any
);
  logic [POS_W-1:0]  half_off;
  logic [DATA_W-1:0] be_bits;

  always_comb begin
    pair     = addr[ADDR_W-1:4];
    half_off = addr[3] ? POS_W'(WORD_W) : '0;
    lane     = lane_of(wsel);
    case (wsel)
      WS_2:    pos = half_off + POS_W'({addr[2:1], 1'b0});
      WS_4:    pos = half_off + POS_W'({addr[2], 2'b00});
      WS_9:    pos = half_off;
      WS_18:   pos = '0;
      default: pos = half_off + POS_W'(addr[2:0]);
    endcase
    if (wsel == WS_18) be_bits = {{WORD_W{be[1]}}, {WORD_W{be[0]}}};
    else               be_bits = {DATA_W{be[0]}};
    wr_lane = ce ? (lane & be_bits) : '0;
    wr_any  = |wr_lane;
  end
endmodule

// File: rtl/mwdp_store.sv
module mwdp_store
  import mwdp_pkg::*;
#(
  parameter logic [INIT_BITS-1:0] INIT_VEC = '0
) (
  input  logic               clk,
  input  logic [PAIR_AW-1:0] a_pair,
  input  logic [POS_W-1:0]   a_pos,
  input  logic [DATA_W-1:0]  a_wr_lane,
  input  logic [DATA_W-1:0]  a_wdata,
  output logic [DATA_W-1:0]  a_win,
  input  logic [PAIR_AW-1:0] b_pair,
  input  logic [POS_W-1:0]   b_pos,
  input  logic [DATA_W-1:0]  b_wr_lane,
  input  logic [DATA_W-1:0]  b_wdata,
  output logic [DATA_W-1:0]  b_win
);
  logic [DATA_W-1:0] mem [PAIRS];

  initial begin
    for (int i = 0; i < PAIRS; i++) mem[i] = INIT_VEC[i*DATA_W +: DATA_W];
  end

  logic [DATA_W-1:0] a_wm, a_wd, b_wm, b_wd, b_wm_s, b_wd_s, a_next, b_next;
  logic              same_pair, a_wr, b_wr;

  always_comb begin
    a_wm      = a_wr_lane << a_pos;
    a_wd      = (a_wdata & a_wr_lane) << a_pos;
    b_wm      = b_wr_lane << b_pos;
    b_wd      = (b_wdata & b_wr_lane) << b_pos;
    a_wr      = |a_wm;
    b_wr      = |b_wm;
    same_pair = (a_pair == b_pair);
    b_wm_s    = same_pair ? b_wm : '0;
    b_wd_s    = same_pair ? b_wd : '0;
    // port A bits overrule port B bits within a shared pair
    a_next    = (mem[a_pair] & ~a_wm & ~b_wm_s) | a_wd | (b_wd_s & ~a_wm);
    b_next    = (mem[b_pair] & ~b_wm) | b_wd;
  end

  always_ff @(posedge clk) begin
    if (a_wr) mem[a_pair] <= a_next;
    if (b_wr && !(same_pair && a_wr)) mem[b_pair] <= b_next;
  end

  assign a_win = mem[a_pair];
  assign b_win = mem[b_pair];
endmodule

// File: rtl/mwdp_read_reg.sv
module mwdp_read_reg
  import mwdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [1:0]        rdw,
  input  logic [DATA_W-1:0] win,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] lane,
  input  logic [DATA_W-1:0] wr_lane,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_any,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] old_bits, nxt;
  logic              load;

  always_comb begin
    old_bits = (win >> pos) & lane;
    if (rdw == RDW_NEW) nxt = (old_bits & ~wr_lane) | (wdata & wr_lane);
    else                nxt = old_bits;
    load = ce && !(rdw == RDW_HOLD && wr_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (load) rdata <= nxt;
  end
endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
  import mwdp_pkg::*;
#(
  parameter logic [INIT_BITS-1:0] INIT_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_ce,
  input  logic [2:0]        a_wsel,
  input  logic [1:0]        a_rdw,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [BE_W-1:0]   a_be,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_ce,
  input  logic [2:0]        b_wsel,
  input  logic [1:0]        b_rdw,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [BE_W-1:0]   b_be,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int NPORT = 2;

  logic              ce_v    [NPORT];
  logic [2:0]        wsel_v  [NPORT];
  logic [1:0]        rdw_v   [NPORT];
  logic [ADDR_W-1:0] addr_v  [NPORT];
  logic [DATA_W-1:0] wdata_v [NPORT];
  logic [BE_W-1:0]   be_v    [NPORT];
  logic [DATA_W-1:0] rdata_v [NPORT];
  logic [PAIR_AW-1:0] pair_v [NPORT];
  logic [POS_W-1:0]  pos_v   [NPORT];
  logic [DATA_W-1:0] lane_v  [NPORT];
  logic [DATA_W-1:0] wlane_v [NPORT];
  logic              wany_v  [NPORT];
  logic [DATA_W-1:0] win_v   [NPORT];

  assign ce_v[0] = a_ce;       assign ce_v[1] = b_ce;
  assign wsel_v[0] = a_wsel;   assign wsel_v[1] = b_wsel;
  assign rdw_v[0] = a_rdw;     assign rdw_v[1] = b_rdw;
  assign addr_v[0] = a_addr;   assign addr_v[1] = b_addr;
  assign wdata_v[0] = a_wdata; assign wdata_v[1] = b_wdata;
  assign be_v[0] = a_be;       assign be_v[1] = b_be;
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mwdp_port_map u_map (
      .ce(ce_v[p]), .wsel(wsel_v[p]), .addr(addr_v[p]), .be(be_v[p]),
      .pair(pair_v[p]), .pos(pos_v[p]), .lane(lane_v[p]),
      .wr_lane(wlane_v[p]), .wr_any(wany_v[p])
    );
    mwdp_read_reg u_rd (
      .clk(clk), .rst_n(rst_n), .ce(ce_v[p]), .rdw(rdw_v[p]),
      .win(win_v[p]), .pos(pos_v[p]), .lane(lane_v[p]),
      .wr_lane(wlane_v[p]), .wdata(wdata_v[p]), .wr_any(wany_v[p]),
      .rdata(rdata_v[p])
    );
  end

  mwdp_store #(.INIT_VEC(INIT_VEC)) u_store (
    .clk(clk),
    .a_pair(pair_v[0]), .a_pos(pos_v[0]), .a_wr_lane(wlane_v[0]),
    .a_wdata(wdata_v[0]), .a_win(win_v[0]),
    .b_pair(pair_v[1]), .b_pos(pos_v[1]), .b_wr_lane(wlane_v[1]),
    .b_wdata(wdata_v[1]), .b_win(win_v[1])
  );
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk
  import mwdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              a_ce,
  input logic [2:0]        a_wsel,
  input logic [1:0]        a_rdw,
  input logic [DATA_W-1:0] a_wdata,
  input logic [BE_W-1:0]   a_be,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_ce,
  input logic [2:0]        b_wsel,
  input logic [1:0]        b_rdw,
  input logic [DATA_W-1:0] b_wdata,
  input logic [BE_W-1:0]   b_be,
  input logic [DATA_W-1:0] b_rdata
);
  // R6
  ce_idle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ce |=> $stable(a_rdata));
  // R6
  ce_idle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_ce |=> $stable(b_rdata));
  // R7
  hold_mode_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce && a_rdw == 2'd0 && (a_be[0] || (a_wsel == 3'd4 && a_be[1]))
    |=> $stable(a_rdata));
  // R7
  hold_mode_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_ce && b_rdw == 2'd0 && (b_be[0] || (b_wsel == 3'd4 && b_be[1]))
    |=> $stable(b_rdata));
  // R3
  narrow_top_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce && a_rdw != 2'd0 && a_wsel <= 3'd2 |=> a_rdata[DATA_W-1:4] == '0);
  // R3
  narrow_top_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_ce && b_rdw != 2'd0 && b_wsel <= 3'd2 |=> b_rdata[DATA_W-1:4] == '0);
  // R9
  new_full_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_ce && a_rdw == 2'd2 && a_wsel == 3'd4 && a_be == 2'b11
    |=> a_rdata == $past(a_wdata));
  // R9
  new_full_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_ce && b_rdw == 2'd2 && b_wsel == 3'd4 && b_be == 2'b11
    |=> b_rdata == $past(b_wdata));
endmodule

bind mwdp_ram mwdp_ram_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .a_ce(a_ce), .a_wsel(a_wsel), .a_rdw(a_rdw), .a_wdata(a_wdata),
  .a_be(a_be), .a_rdata(a_rdata),
  .b_ce(b_ce), .b_wsel(b_wsel), .b_rdw(b_rdw), .b_wdata(b_wdata),
  .b_be(b_be), .b_rdata(b_rdata)
);

// File: tb/mwdp_ram_tb_top.sv
module mwdp_ram_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        a_ce, b_ce;
  logic [2:0]  a_wsel, b_wsel;
  logic [1:0]  a_rdw, b_rdw;
  logic [12:0] a_addr, b_addr;
  logic [17:0] a_wdata, b_wdata;
  logic [1:0]  a_be, b_be;
  logic [17:0] a_rdata, b_rdata;

  mwdp_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_wsel(a_wsel), .a_rdw(a_rdw), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_be(a_be), .a_rdata(a_rdata),
    .b_ce(b_ce), .b_wsel(b_wsel), .b_rdw(b_rdw), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_be(b_be), .b_rdata(b_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit ref_mem [0:9215];
  logic [17:0] exp_a = '0, exp_b = '0;

  function automatic int wlen(input logic [2:0] w);
    case (w)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 9;
      3'd4: return 18;
      default: return 1;
    endcase
  endfunction

  // flat bit index of bit i of an access (word = 9 bits)
  function automatic int bitidx(input logic [12:0] ad, input logic [2:0] w, input int i);
    int a = int'(ad);
    case (w)
      3'd1: return (a / 8) * 9 + (a % 8) / 2 * 2 + i;
      3'd2: return (a / 8) * 9 + (a % 8) / 4 * 4 + i;
      3'd3: return (a / 8) * 9 + i;
      3'd4: return ((a / 16) * 2 + i / 9) * 9 + i % 9;
      default: return (a / 8) * 9 + a % 8;
    endcase
  endfunction

  function automatic bit bit_en(input logic [2:0] w, input logic [1:0] be, input int i);
    if (w == 3'd4) return be[i / 9];
    return be[0];
  endfunction

  function automatic bit is_wr(input logic ce, input logic [2:0] w, input logic [1:0] be);
    return ce && (be[0] || (w == 3'd4 && be[1]));
  endfunction

  function automatic logic [17:0] predict(input logic ce, input logic [2:0] w,
      input logic [1:0] m, input logic [12:0] ad, input logic [17:0] wd,
      input logic [1:0] be, input logic [17:0] prev);
    logic [17:0] r = '0;
    if (!ce) return prev;
    if (m == 2'd0 && is_wr(ce, w, be)) return prev;
    for (int i = 0; i < wlen(w); i++) begin
      r[i] = ref_mem[bitidx(ad, w, i)];
      if (m == 2'd2 && bit_en(w, be, i)) r[i] = wd[i];
    end
    return r;
  endfunction

  task automatic apply_write(input logic ce, input logic [2:0] w, input logic [12:0] ad,
      input logic [17:0] wd, input logic [1:0] be);
    if (ce)
      for (int i = 0; i < wlen(w); i++)
        if (bit_en(w, be, i)) ref_mem[bitidx(ad, w, i)] = wd[i];
  endtask

  function automatic string auto_tag(input logic ce, input logic [2:0] w, input logic [1:0] m,
      input logic [1:0] be, input bit other_wr);
    if (!ce) return "R6";
    if (is_wr(ce, w, be)) begin
      if (m == 2'd0) return "R7";
      if (m == 2'd2) return "R9";
      return "R8";
    end
    if (other_wr) return "R11";
    return "R2";
  endfunction

  task automatic check(input string tag, input string port, input logic [17:0] act,
      input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port %s actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic do_cycle(
      input logic ace, input logic [2:0] aw, input logic [1:0] am, input logic [12:0] aad,
      input logic [17:0] awd, input logic [1:0] abe,
      input logic bce, input logic [2:0] bw, input logic [1:0] bm, input logic [12:0] bad,
      input logic [17:0] bwd, input logic [1:0] bbe, input string tag);
    string ta, tb;
    a_ce = ace; a_wsel = aw; a_rdw = am; a_addr = aad; a_wdata = awd; a_be = abe;
    b_ce = bce; b_wsel = bw; b_rdw = bm; b_addr = bad; b_wdata = bwd; b_be = bbe;
    exp_a = predict(ace, aw, am, aad, awd, abe, exp_a);
    exp_b = predict(bce, bw, bm, bad, bwd, bbe, exp_b);
    apply_write(bce, bw, bad, bwd, bbe);
    apply_write(ace, aw, aad, awd, abe);   // port A last: it wins (R10)
    ta = (tag != "") ? tag : auto_tag(ace, aw, am, abe, is_wr(bce, bw, bbe));
    tb = (tag != "") ? tag : auto_tag(bce, bw, bm, bbe, is_wr(ace, aw, abe));
    @(negedge clk);
    check(ta, "A", a_rdata, exp_a);
    check(tb, "B", b_rdata, exp_b);
  endtask

  task automatic idle_b_rd_a(input logic [2:0] w, input logic [1:0] m, input logic [12:0] ad,
      input string tag);
    do_cycle(1'b1, w, m, ad, '0, 2'b00, 1'b0, 3'd0, 2'd1, '0, '0, 2'b00, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run hung actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_ce = 0; a_wsel = 0; a_rdw = 0; a_addr = 0; a_wdata = 0; a_be = 0;
    b_ce = 0; b_wsel = 0; b_rdw = 0; b_addr = 0; b_wdata = 0; b_be = 0;
    repeat (3) @(negedge clk);
    check("R1", "A", a_rdata, '0);
    check("R1", "B", b_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: unwritten storage reads as the (zero) init vector, one cycle later
    idle_b_rd_a(3'd4, 2'd1, 13'h0100, "R12");
    // R2: 18-bit write, read back through B at 1, 4 and 9 bits
    do_cycle(1'b1, 3'd4, 2'd1, 13'h0010, 18'h2a5c3, 2'b11,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R2");
    for (int i = 0; i < 18; i++)
      do_cycle(1'b0, 3'd0, 2'd1, '0, '0, 2'b00,
               1'b1, 3'd0, 2'd1, 13'(16 + i), '0, 2'b00, "R2");
    do_cycle(1'b0, 3'd0, 2'd1, '0, '0, 2'b00, 1'b1, 3'd2, 2'd1, 13'h0014, '0, 2'b00, "R2");
    do_cycle(1'b0, 3'd0, 2'd1, '0, '0, 2'b00, 1'b1, 3'd3, 2'd1, 13'h0018, '0, 2'b00, "R2");
    // R3: narrow read leaves upper bits zero
    do_cycle(1'b1, 3'd4, 2'd1, 13'h0040, 18'h3ffff, 2'b11,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R3");
    idle_b_rd_a(3'd1, 2'd1, 13'h0042, "R3");
    // R4: misaligned low address bits ignored
    do_cycle(1'b1, 3'd3, 2'd1, 13'h004f, 18'h00155, 2'b01,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R4");
    idle_b_rd_a(3'd3, 2'd1, 13'h0049, "R4");
    idle_b_rd_a(3'd4, 2'd1, 13'h004b, "R4");
    // R5: upper enable only at 18 bits; bit 1 alone ignored at narrower widths
    do_cycle(1'b1, 3'd4, 2'd1, 13'h0060, 18'h3ffff, 2'b10,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R5");
    idle_b_rd_a(3'd4, 2'd1, 13'h0060, "R5");
    do_cycle(1'b1, 3'd3, 2'd1, 13'h0060, 18'h001ff, 2'b10,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R5");
    idle_b_rd_a(3'd4, 2'd1, 13'h0060, "R5");
    // R6: disabled port neither writes nor reads
    do_cycle(1'b0, 3'd4, 2'd1, 13'h0080, 18'h12345, 2'b11,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R6");
    idle_b_rd_a(3'd4, 2'd1, 13'h0080, "R6");
    // R7 / R8 / R9 on port A with a half write
    do_cycle(1'b1, 3'd4, 2'd0, 13'h00a0, 18'h15555, 2'b01,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R7");
    do_cycle(1'b1, 3'd4, 2'd1, 13'h00a0, 18'h0aaaa, 2'b11,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R8");
    do_cycle(1'b1, 3'd4, 2'd2, 13'h00a0, 18'h3c0f0, 2'b10,
             1'b0, 3'd0, 2'd1, '0, '0, 2'b00, "R9");
    // R10: both ports write one word
    do_cycle(1'b1, 3'd3, 2'd1, 13'h00c0, 18'h0012f, 2'b01,
             1'b1, 3'd3, 2'd1, 13'h00c0, 18'h001d0, 2'b01, "R10");
    idle_b_rd_a(3'd3, 2'd1, 13'h00c0, "R10");
    // R11: B reads what A writes in the same cycle
    do_cycle(1'b1, 3'd3, 2'd1, 13'h00c0, 18'h000aa, 2'b01,
             1'b1, 3'd3, 2'd2, 13'h00c0, '0, 2'b00, "R11");

    // every pairing of widths and modes over a small window
    for (int wa = 0; wa < 5; wa++)
      for (int wb = 0; wb < 5; wb++)
        for (int mm = 0; mm < 9; mm++)
          for (int k = 0; k < 28; k++)
            do_cycle(($urandom % 8) != 0, 3'(wa), 2'(mm / 3), 13'($urandom_range(0, 63)),
                     18'($urandom), 2'($urandom),
                     ($urandom % 8) != 0, 3'(wb), 2'(mm % 3), 13'($urandom_range(0, 63)),
                     18'($urandom), 2'($urandom), "");

    summary();
    $finish;
  end
endmodule